// File: doc/BRIEF.md
# Low-Power Weighted Hold-Latch Pattern Generator

This block produces pseudorandom scan stimulus whose toggle rate can be turned down. A 16-stage ring-form pseudorandom generator feeds a bank of hold latches, one latch per stage. Each latch either passes its generator bit straight through or keeps the value it showed on the previous cycle. A phase shifter made of three-input XORs turns the latch outputs into the scan-chain inputs. A scan chain whose three source latches are all holding therefore receives a constant value.

Each latch's mode comes from a per-stage control register. That register is refreshed at each pattern boundary from an auxiliary enable shift register. While scan shifting runs, the shift register is filled with enable bits that are 1 with a probability set by a 4-bit switching code. The code ORs together AND terms over generator stages that carry weights 1/2, 1/4, 1/8 and 1/16. An all-zero code switches the low-power function off, so every latch becomes transparent.

Top module: `lp_pattern_gen`

## Requirements
- R1: While rst_ni is low, the generator state is the seed 16'hACE1, the enable shift register is all zeros, every control bit is 1 (transparent) and every held latch value is 0. As a result, scan_o right after reset reflects the seed directly.
- R2: The generator advances only in cycles where shift_en_i is 1. Its next state is the current state rotated by one toward higher indices (bit i takes bit i-1, bit 0 takes bit 15). Three bits are then XORed with other stages: bit 2 with old bit 12, bit 6 with old bit 9, and bit 11 with old bit 4.
- R3: Starting from the nonzero seed, the generator state is never all zeros.
- R4: The weighted enable bit is the OR of four enabled terms taken from the current generator state p. Code bit 3 enables p[0]. Code bit 2 enables p[1]&p[2]. Code bit 1 enables p[3]&p[4]&p[5]. Code bit 0 enables p[6]&p[7]&p[8]&p[9]. A code of 4'b0100 therefore gives ones about a quarter of the time.
- R5: In a cycle with shift_en_i at 1, the enable shift register moves one place toward its MSB and takes the weighted enable bit into bit 0.
- R6: A cycle with pat_load_i at 1 copies the enable shift register's current contents into the control register. The copy takes effect in the next cycle.
- R7: When the code is nonzero, a latch whose control bit is 1 outputs the current generator bit of its stage. A latch whose control bit is 0 outputs the same value it gave in the previous cycle.
- R8: When the switching code is 4'b0000, every latch is transparent and the control register contents have no effect on scan_o.
- R9: scan_o[c] is the XOR of latch outputs c, (c+5) mod 16 and (c+11) mod 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_code_i | input | 4 | Switching code that selects the enable-bit probability; 0 turns low-power mode off |
| pat_load_i | input | 1 | Pattern-boundary strobe that loads the control register |
| shift_en_i | input | 1 | Advances the generator and the enable shift register |
| scan_o | output | 8 | Scan-chain input bits from the phase shifter |

## Verification
The hardest state to reach is a latch that holds across many generator steps while its neighbours keep toggling. Which latches hold depends on enable bits drawn from the generator itself, and none of them can be set directly. The stimulus uses low-weight codes such as 4'b0001, which leave most control bits at 0 after a full fill of the shift register. It then keeps shifting after the load, so that held and transparent stages separate visibly at scan_o. A bench model tracks which stages hold. A final sequence switches the code to zero while such a sparse control word is in place, to show that the held values are ignored.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int unsigned NUM_INJ   = 3;
  localparam int unsigned NUM_TERMS = 4;

  // first generator stage used by weighted term k (term k ANDs k+1 stages)
  function automatic int unsigned term_start(input int unsigned k);
    return (k * (k + 1)) / 2;
  endfunction
endpackage

// File: rtl/lpg_ring_prpg.sv
module lpg_ring_prpg #(
  parameter int unsigned N_STAGES = 16,
  parameter logic [N_STAGES-1:0] SEED = 16'hACE1,
  parameter int unsigned INJ_DST [lpg_pkg::NUM_INJ] = '{2, 6, 11},
  parameter int unsigned INJ_SRC [lpg_pkg::NUM_INJ] = '{12, 9, 4}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  output logic [N_STAGES-1:0] state_o
);
  logic [N_STAGES-1:0] state_q, inj, state_d;

  always_comb begin
    inj = '0;
    for (int k = 0; k < int'(lpg_pkg::NUM_INJ); k++) begin
      inj[INJ_DST[k]] = state_q[INJ_SRC[k]];
    end
    state_d = {state_q[N_STAGES-2:0], state_q[N_STAGES-1]} ^ inj;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= state_d;
  end

  assign state_o = state_q;

  p_prpg_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  p_prpg_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));
endmodule

// File: rtl/lpg_weight_ctrl.sv
module lpg_weight_ctrl #(
  parameter int unsigned N_STAGES = 16,
  parameter int unsigned CODE_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STAGES-1:0] prpg_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                shift_i,
  input  logic                load_i,
  output logic [N_STAGES-1:0] ctrl_o
);
  logic [CODE_W-1:0]   term;
  logic                wbit;
  logic [N_STAGES-1:0] sr_q, ctrl_q;

  // term k fires with probability 2^-(k+1); code MSB enables the heaviest term
  for (genvar k = 0; k < CODE_W; k++) begin : g_term
    localparam int unsigned START = lpg_pkg::term_start(k);
    assign term[k] = code_i[CODE_W-1-k] & (&prpg_i[START +: k+1]);
  end
  assign wbit = |term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      ctrl_q <= '1;
    end else begin
      if (shift_i) sr_q   <= {sr_q[N_STAGES-2:0], wbit};
      if (load_i)  ctrl_q <= sr_q;
    end
  end

  assign ctrl_o = ctrl_q;

  p_sr_insert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_q[0] == $past(wbit));

  p_ctrl_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(load_i)) |-> ctrl_q == $past(sr_q));
endmodule

// File: rtl/lpg_hold_bank.sv
module lpg_hold_bank #(
  parameter int unsigned N_STAGES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STAGES-1:0] prpg_i,
  input  logic [N_STAGES-1:0] xp_i,
  output logic [N_STAGES-1:0] lat_o
);
  logic [N_STAGES-1:0] held_q;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_lat
    assign lat_o[i] = xp_i[i] ? prpg_i[i] : held_q[i];

    p_hold_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !xp_i[i]) |-> lat_o[i] == $past(lat_o[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= lat_o;
  end
endmodule

// File: rtl/lpg_phase_shifter.sv
module lpg_phase_shifter #(
  parameter int unsigned N_STAGES = 16,
  parameter int unsigned N_CHAINS = 8,
  parameter int unsigned OFF_B    = 5,
  parameter int unsigned OFF_C    = 11
) (
  input  logic [N_STAGES-1:0] lat_i,
  output logic [N_CHAINS-1:0] scan_o
);
  for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain
    localparam int unsigned TA = c % N_STAGES;
    localparam int unsigned TB = (c + OFF_B) % N_STAGES;
    localparam int unsigned TC = (c + OFF_C) % N_STAGES;
    assign scan_o[c] = lat_i[TA] ^ lat_i[TB] ^ lat_i[TC];
  end
endmodule

// File: rtl/lp_pattern_gen.sv
module lp_pattern_gen #(
  parameter int unsigned N_STAGES = 16,
  parameter int unsigned N_CHAINS = 8,
  parameter int unsigned CODE_W   = 4,
  parameter logic [N_STAGES-1:0] SEED = 16'hACE1,
  parameter int unsigned INJ_DST [lpg_pkg::NUM_INJ] = '{2, 6, 11},
  parameter int unsigned INJ_SRC [lpg_pkg::NUM_INJ] = '{12, 9, 4},
  parameter int unsigned PS_OFF_B = 5,
  parameter int unsigned PS_OFF_C = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W-1:0]   sw_code_i,
  input  logic                pat_load_i,
  input  logic                shift_en_i,
  output logic [N_CHAINS-1:0] scan_o
);
  logic [N_STAGES-1:0] prpg, ctrl, xp, lat;
  logic                lp_off;

  lpg_ring_prpg #(
    .N_STAGES(N_STAGES), .SEED(SEED), .INJ_DST(INJ_DST), .INJ_SRC(INJ_SRC)
  ) i_prpg (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(shift_en_i), .state_o(prpg)
  );

  lpg_weight_ctrl #(.N_STAGES(N_STAGES), .CODE_W(CODE_W)) i_wctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .prpg_i(prpg), .code_i(sw_code_i),
    .shift_i(shift_en_i), .load_i(pat_load_i), .ctrl_o(ctrl)
  );

  assign lp_off = ~|sw_code_i;
  assign xp     = ctrl | {N_STAGES{lp_off}};

  lpg_hold_bank #(.N_STAGES(N_STAGES)) i_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .prpg_i(prpg), .xp_i(xp), .lat_o(lat)
  );

  lpg_phase_shifter #(
    .N_STAGES(N_STAGES), .N_CHAINS(N_CHAINS), .OFF_B(PS_OFF_B), .OFF_C(PS_OFF_C)
  ) i_ps (
    .lat_i(lat), .scan_o(scan_o)
  );

  p_lp_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_code_i == '0) |-> lat == prpg);
endmodule

// File: tb/test_lp_pattern_gen.sv
`timescale 1ns/1ps
module test_lp_pattern_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] code_r = 4'b0100;
  logic ld_r = 1'b0, sh_r = 1'b0;
  logic [7:0] scan;

  always #2 clk = ~clk;

  lp_pattern_gen i_lp_pattern_gen (
    .clk_i(clk), .rst_ni(rst_n), .sw_code_i(code_r),
    .pat_load_i(ld_r), .shift_en_i(sh_r), .scan_o(scan)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_prpg, m_sr, m_ctrl, m_hold;

  // code, shift count, load flag
  localparam logic [12:0] VEC [10] = '{
    {4'b0100, 8'd16, 1'b1}, {4'b1111, 8'd20, 1'b1}, {4'b0001, 8'd16, 1'b1},
    {4'b0001, 8'd24, 1'b0}, {4'b1010, 8'd18, 1'b1}, {4'b0011, 8'd30, 1'b1},
    {4'b1000, 8'd16, 1'b1}, {4'b0110, 8'd22, 1'b1}, {4'b0001, 8'd40, 1'b1},
    {4'b0010, 8'd25, 1'b0}};

  function automatic logic [15:0] ring_next(input logic [15:0] q);
    logic [15:0] n;
    for (int i = 0; i < 16; i++) n[i] = q[(i + 15) % 16];
    n[2]  ^= q[12];
    n[6]  ^= q[9];
    n[11] ^= q[4];
    return n;
  endfunction

  function automatic logic [7:0] shifter(input logic [15:0] l);
    logic [7:0] s;
    for (int c = 0; c < 8; c++) s[c] = l[c] ^ l[(c + 5) % 16] ^ l[(c + 11) % 16];
    return s;
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (scan !== exp) begin
      errors++;
      $display("FAIL %s: scan_o=%h expected=%h", tag, scan, exp);
    end
  endtask

  task automatic step(input logic [3:0] code, input logic sh, input logic ld,
                      input string tag);
    logic [15:0] lat;
    logic wb;
    @(negedge clk);
    code_r = code; sh_r = sh; ld_r = ld;
    #1;
    for (int i = 0; i < 16; i++)
      lat[i] = ((code == 4'd0) || m_ctrl[i]) ? m_prpg[i] : m_hold[i];
    check(shifter(lat), tag);
    wb = (code[3] & m_prpg[0]) | (code[2] & m_prpg[1] & m_prpg[2]) |
         (code[1] & m_prpg[3] & m_prpg[4] & m_prpg[5]) |
         (code[0] & m_prpg[6] & m_prpg[7] & m_prpg[8] & m_prpg[9]);
    @(posedge clk);
    m_hold = lat;
    if (ld) m_ctrl = m_sr;
    if (sh) begin
      m_sr   = {m_sr[14:0], wb};
      m_prpg = ring_next(m_prpg);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_prpg = 16'hACE1; m_sr = '0; m_ctrl = '1; m_hold = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(shifter(16'hACE1), "R1 reset state");
    rst_n = 1'b1;
    step(4'b0100, 1'b0, 1'b0, "R1 idle after reset");
    step(4'b0100, 1'b0, 1'b1, "R1 load of empty shift register");
    step(4'b0100, 1'b0, 1'b0, "R7 all stages held after empty load");
    step(4'b0100, 1'b1, 1'b0, "R7 R2 held while generator moves");

    for (int v = 0; v < 10; v++) begin
      logic [3:0] c;
      c = VEC[v][12:9];
      for (int s = 0; s < int'(VEC[v][8:1]); s++)
        step(c, 1'b1, 1'b0, "R2 R3 R4 R5 R9 shifting");
      if (VEC[v][0]) step(c, 1'b0, 1'b1, "R6 pattern load");
      for (int s = 0; s < 6; s++) step(c, 1'b1, 1'b0, "R7 R9 after load");
      step(c, 1'b0, 1'b0, "R2 idle stable");
    end

    // sparse control word, then low-power off: held values must not matter
    for (int s = 0; s < 16; s++) step(4'b0001, 1'b1, 1'b0, "R4 R5 sparse fill");
    step(4'b0001, 1'b0, 1'b1, "R6 sparse load");
    for (int s = 0; s < 4; s++) step(4'b0001, 1'b1, 1'b0, "R7 sparse hold");
    for (int s = 0; s < 6; s++) step(4'b0000, 1'b1, 1'b0, "R8 code zero transparent");
    step(4'b0000, 1'b0, 1'b1, "R8 load under code zero");
    for (int s = 0; s < 4; s++) step(4'b0000, 1'b1, 1'b0, "R8 after load");
    for (int s = 0; s < 4; s++) step(4'b1000, 1'b1, 1'b0, "R7 code restored");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule